// File: doc/BRIEF.md
# UHS Operating Condition Negotiator

This block carries out the operating-condition step of card start-up for a host that can switch its signalling to 1.8 V. Its capability inputs are static: three UHS mode support flags, three supply-voltage support flags and three 8-bit maximum-current fields. From them it assembles the 32-bit argument for the operating-condition command. It issues that command over a plain request/acknowledge handshake and then examines the 32-bit response that comes back.

When the response shows that the card both reports capacity status and accepts 1.8 V, and the bus is not in SPI mode, the block pulses a start signal to an external voltage-switch sequencer and waits for a result. If the switch fails, the block removes the 1.8 V request from the argument and runs the command step once more. There is no further retry. The block ends in a done state that is either clean or carries an error. It also reports the final argument and whether 1.8 V signalling was reached. Command framing, CRC and the physical bus are handled elsewhere.

Top module: `uhs_opcond_negotiator`

## Requirements
- R1: While reset is held, and after it is released, `done`, `error`, `cmd_req`, `sw_start` and `low_volt_ok` are all 0.
- R2: Argument bit 24 (1.8 V request) is 1 only if at least one of `uhs_caps` bit 0 (SDR50), bit 1 (SDR104) or bit 2 (DDR50) is set. SDR104 counts as SDR50 support as well.
- R3: Argument bit 28 (extended power) is 1 when some rail, with its support flag set, has current field × 4 mA > 150 mA, which means a field value of 38 or more. Fields are laid out as 3.3 V in `max_current[7:0]`, 3.0 V in `[15:8]` and 1.8 V in `[23:16]`. The rail support flags in `volt_caps` use the same order: bit 0 is 3.3 V, bit 1 is 3.0 V, bit 2 is 1.8 V.
- R4: A current field whose rail support flag is clear has no effect on bit 28, whatever its value.
- R5: Argument bit 30 equals `if_cond_ok`. Bits [23:0] equal `vdd_window`. Bits 31, 29 and 27:25 are 0.
- R6: After `start`, `cmd_req` rises and stays high, with `cmd_arg` unchanged, until a cycle in which `cmd_ack` is high.
- R7: `sw_start` pulses for exactly one cycle only when the accepted response has bit 30 and bit 24 both set, no command error is reported and `spi_mode` is 0. In every other case the run ends without a switch, with `low_volt_ok` = 0.
- R8: When the switch reports success, the block ends with `done`=1, `error`=0, `low_volt_ok`=1, and `final_arg` still has bit 24 set.
- R9: When the first switch fails, the command is issued again with bit 24 cleared and every other bit unchanged. A retry that needs no switch ends with `done`=1, `error`=0 and `low_volt_ok`=0.
- R10: A second switch failure ends with `done`=1 and `error`=1.
- R11: A response delivered with `cmd_err` high ends the run with `done`=1 and `error`=1, and no switch is started.
- R12: `done` stays high until the next `start`, and it is 0 in the cycle after that `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a negotiation (taken when idle or done) |
| uhs_caps | input | 3 | Mode support: bit0 SDR50, bit1 SDR104, bit2 DDR50 |
| volt_caps | input | 3 | Supply support: bit0 3.3 V, bit1 3.0 V, bit2 1.8 V |
| max_current | input | 24 | Three 8-bit current fields in units of 4 mA |
| if_cond_ok | input | 1 | Earlier interface-condition check succeeded |
| spi_mode | input | 1 | Bus operates in SPI mode |
| vdd_window | input | 24 | Voltage window placed in argument bits [23:0] |
| cmd_req | output | 1 | Command request, held until acknowledged |
| cmd_arg | output | 32 | Argument of the pending command |
| cmd_ack | input | 1 | Response valid for the pending command |
| cmd_err | input | 1 | Command failed (qualified by cmd_ack) |
| cmd_resp | input | 32 | Response word (qualified by cmd_ack) |
| sw_start | output | 1 | One-cycle kick to the voltage-switch sequencer |
| sw_done | input | 1 | Sequencer result valid |
| sw_ok | input | 1 | Sequencer reports success (qualified by sw_done) |
| done | output | 1 | Negotiation finished |
| error | output | 1 | Finished with failure |
| low_volt_ok | output | 1 | 1.8 V signalling reached |
| final_arg | output | 32 | Argument used by the last command issued |

## Verification
The hardest state to reach from the ports is the second switch failure. To get there, the first failure has to trigger a reissue with the 1.8 V request cleared, and the responder then has to claim 1.8 V acceptance anyway so that a second switch starts. The bench acts as both the card and the sequencer. In one scenario it answers both commands with the acceptance bits set and reports failure on both switches. It counts `sw_start` pulses and records the argument of each issued command, which shows whether the reissue really dropped bit 24.

// File: rtl/uhs_opcond_pkg.sv
// Shared constants and state type for the operating-condition negotiator.
// Assumes a 32-bit argument/response word and three supply rails.
package uhs_opcond_pkg;
    localparam int ARG_W     = 32;
    localparam int WINDOW_W  = 24;
    localparam int NUM_RAILS = 3;
    localparam int NUM_MODES = 3;
    localparam int BIT_S18   = 24;   // 1.8 V request / accepted
    localparam int BIT_XPC   = 28;   // extended power control
    localparam int BIT_HCS   = 30;   // capacity support / status

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_SW_KICK,
        ST_SW_WAIT,
        ST_DONE_OK,
        ST_DONE_ERR
    } neg_state_t;
endpackage

// File: rtl/uhs_arg_builder.sv
// Builds the operating-condition argument from static capabilities.
// The logic is purely combinational. Inputs are assumed stable while a
// negotiation is running, and the result is captured when start is taken.
module uhs_arg_builder
    import uhs_opcond_pkg::*;
#(
    parameter int CUR_W    = 8,
    parameter int UNIT_MA  = 4,
    parameter int LIMIT_MA = 150
) (
    input  logic [NUM_MODES-1:0]       uhs_caps,
    input  logic [NUM_RAILS-1:0]       volt_caps,
    input  logic [NUM_RAILS*CUR_W-1:0] max_current,
    input  logic                       if_cond_ok,
    input  logic [WINDOW_W-1:0]        vdd_window,
    output logic [ARG_W-1:0]           arg
);
    localparam int PROD_W = CUR_W + $clog2(UNIT_MA + 1) + 1;

    logic [NUM_RAILS-1:0] rail_high;
    logic                 sdr50_eff;
    logic                 s18_req;

    // Per-rail check: the field counts only when its rail is supported.
    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        logic [CUR_W-1:0]  field;
        logic [PROD_W-1:0] milliamps;
        assign field        = max_current[r*CUR_W +: CUR_W];
        assign milliamps    = PROD_W'(field) * PROD_W'(UNIT_MA);
        assign rail_high[r] = volt_caps[r] && (milliamps > PROD_W'(LIMIT_MA));
    end

    // SDR104 support implies SDR50 support.
    assign sdr50_eff = uhs_caps[0] | uhs_caps[1];
    assign s18_req   = sdr50_eff | uhs_caps[2];

    // Assemble the argument word, with reserved bits held at zero.
    always_comb begin
        arg                 = '0;
        arg[WINDOW_W-1:0]   = vdd_window;
        arg[BIT_S18]        = s18_req;
        arg[BIT_XPC]        = |rail_high;
        arg[BIT_HCS]        = if_cond_ok;
    end
endmodule

// File: rtl/uhs_resp_decoder.sv
// Decides from the response word whether a voltage switch must start.
// The logic is combinational. The result is used only in the cycle the
// response is acknowledged.
module uhs_resp_decoder
    import uhs_opcond_pkg::*;
(
    input  logic [ARG_W-1:0] resp,
    input  logic             spi_mode,
    output logic             want_switch
);
    // A switch needs both capacity status and 1.8 V acceptance, and no SPI mode.
    assign want_switch = !spi_mode && resp[BIT_HCS] && resp[BIT_S18];
endmodule

// File: rtl/uhs_negotiate_fsm.sv
// Sequencer for command issue, the voltage switch and the single retry.
// It assumes each kick to the switch sequencer is answered by one
// sw_done pulse, and that cmd_err is meaningful only together with cmd_ack.
module uhs_negotiate_fsm
    import uhs_opcond_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ARG_W-1:0] built_arg,
    input  logic             cmd_ack,
    input  logic             cmd_err,
    input  logic             want_switch,
    input  logic             sw_done,
    input  logic             sw_ok,
    output logic             cmd_req,
    output logic [ARG_W-1:0] cmd_arg,
    output logic             sw_start,
    output logic             done,
    output logic             error,
    output logic             low_volt_ok
);
    neg_state_t       state;
    logic [ARG_W-1:0] arg_q;
    logic             retried;
    logic             lv_q;

    // Step through the states and hold the argument and retry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            arg_q   <= '0;
            retried <= 1'b0;
            lv_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE_OK, ST_DONE_ERR: begin
                    if (start) begin
                        arg_q   <= built_arg;
                        retried <= 1'b0;
                        lv_q    <= 1'b0;
                        state   <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (cmd_ack) begin
                        if (cmd_err)          state <= ST_DONE_ERR;
                        else if (want_switch) state <= ST_SW_KICK;
                        else                  state <= ST_DONE_OK;
                    end
                end
                ST_SW_KICK: state <= ST_SW_WAIT;
                ST_SW_WAIT: begin
                    if (sw_done) begin
                        if (sw_ok) begin
                            lv_q  <= 1'b1;
                            state <= ST_DONE_OK;
                        end else if (!retried) begin
                            retried        <= 1'b1;
                            arg_q[BIT_S18] <= 1'b0;
                            state          <= ST_CMD;
                        end else begin
                            state <= ST_DONE_ERR;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the outputs from the state and the held registers.
    always_comb begin
        cmd_req     = (state == ST_CMD);
        sw_start    = (state == ST_SW_KICK);
        done        = (state == ST_DONE_OK) || (state == ST_DONE_ERR);
        error       = (state == ST_DONE_ERR);
        cmd_arg     = arg_q;
        low_volt_ok = lv_q;
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_arg));

    // R7
    kick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_start |=> !sw_start);

    // R10
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R8
    lv_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_volt_ok |-> done && !error);

    // R9
    retry_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && retried |-> !cmd_arg[BIT_S18]);
endmodule

// File: rtl/uhs_opcond_negotiator.sv
// Top of the operating-condition negotiator. It connects the argument
// builder, the response decoder and the sequencer. Capability inputs and
// spi_mode are assumed static during a negotiation.
module uhs_opcond_negotiator
    import uhs_opcond_pkg::*;
#(
    parameter int CUR_W    = 8,
    parameter int UNIT_MA  = 4,
    parameter int LIMIT_MA = 150
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_MODES-1:0]       uhs_caps,
    input  logic [NUM_RAILS-1:0]       volt_caps,
    input  logic [NUM_RAILS*CUR_W-1:0] max_current,
    input  logic                       if_cond_ok,
    input  logic                       spi_mode,
    input  logic [WINDOW_W-1:0]        vdd_window,
    output logic                       cmd_req,
    output logic [ARG_W-1:0]           cmd_arg,
    input  logic                       cmd_ack,
    input  logic                       cmd_err,
    input  logic [ARG_W-1:0]           cmd_resp,
    output logic                       sw_start,
    input  logic                       sw_done,
    input  logic                       sw_ok,
    output logic                       done,
    output logic                       error,
    output logic                       low_volt_ok,
    output logic [ARG_W-1:0]           final_arg
);
    logic [ARG_W-1:0] built_arg;
    logic             want_switch;

    uhs_arg_builder #(
        .CUR_W(CUR_W), .UNIT_MA(UNIT_MA), .LIMIT_MA(LIMIT_MA)
    ) u_builder (
        .uhs_caps(uhs_caps), .volt_caps(volt_caps), .max_current(max_current),
        .if_cond_ok(if_cond_ok), .vdd_window(vdd_window), .arg(built_arg)
    );

    uhs_resp_decoder u_decoder (
        .resp(cmd_resp), .spi_mode(spi_mode), .want_switch(want_switch)
    );

    uhs_negotiate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .built_arg(built_arg),
        .cmd_ack(cmd_ack), .cmd_err(cmd_err), .want_switch(want_switch),
        .sw_done(sw_done), .sw_ok(sw_ok), .cmd_req(cmd_req), .cmd_arg(cmd_arg),
        .sw_start(sw_start), .done(done), .error(error), .low_volt_ok(low_volt_ok)
    );

    assign final_arg = cmd_arg;

    // R7
    no_spi_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_start |-> !spi_mode);

    // R11
    err_no_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && cmd_ack && cmd_err |=> !sw_start && error);
endmodule

// File: tb/uhs_opcond_negotiator_test.sv
// Directed bench: one task per scenario, each checking its own results.
module uhs_opcond_negotiator_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  uhs_caps = '0;
    logic [2:0]  volt_caps = '0;
    logic [23:0] max_current = '0;
    logic        if_cond_ok = 1'b0;
    logic        spi_mode = 1'b0;
    logic [23:0] vdd_window = 24'hFF8000;
    logic        cmd_ack = 1'b0;
    logic        cmd_err = 1'b0;
    logic [31:0] cmd_resp = '0;
    logic        sw_done = 1'b0;
    logic        sw_ok = 1'b0;
    logic        cmd_req, sw_start, done, error, low_volt_ok;
    logic [31:0] cmd_arg, final_arg;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int sw_pulses = 0;

    uhs_opcond_negotiator uut (
        .clk(clk), .rst_n(rst_n), .start(start), .uhs_caps(uhs_caps),
        .volt_caps(volt_caps), .max_current(max_current), .if_cond_ok(if_cond_ok),
        .spi_mode(spi_mode), .vdd_window(vdd_window), .cmd_req(cmd_req),
        .cmd_arg(cmd_arg), .cmd_ack(cmd_ack), .cmd_err(cmd_err),
        .cmd_resp(cmd_resp), .sw_start(sw_start), .sw_done(sw_done),
        .sw_ok(sw_ok), .done(done), .error(error), .low_volt_ok(low_volt_ok),
        .final_arg(final_arg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count sequencer kicks and end a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (sw_start) sw_pulses++;
        if (cycles >= 20000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_req();
        for (int i = 0; i < WAIT_LIMIT && !cmd_req; i++) @(negedge clk);
        chk("R6 cmd_req raised", 32'(cmd_req), 32'd1);
    endtask

    task automatic wait_kick();
        for (int i = 0; i < WAIT_LIMIT && !sw_start; i++) @(negedge clk);
        chk("R7 sw_start raised", 32'(sw_start), 32'd1);
    endtask

    task automatic wait_done();
        for (int i = 0; i < WAIT_LIMIT && !done; i++) @(negedge clk);
        chk("R12 done raised", 32'(done), 32'd1);
    endtask

    // Play the card: capture the argument, then deliver a response.
    task automatic answer(input logic [31:0] resp, input logic err, output logic [31:0] seen);
        wait_req();
        seen     = cmd_arg;
        cmd_resp = resp;
        cmd_err  = err;
        cmd_ack  = 1'b1;
        @(negedge clk);
        cmd_ack  = 1'b0;
        cmd_err  = 1'b0;
    endtask

    // Play the switch sequencer.
    task automatic switch_result(input logic ok);
        wait_kick();
        @(negedge clk);
        sw_done = 1'b1;
        sw_ok   = ok;
        @(negedge clk);
        sw_done = 1'b0;
        sw_ok   = 1'b0;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk("R1 done in reset", 32'(done), 32'd0);
        chk("R1 cmd_req in reset", 32'(cmd_req), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 outputs after reset", {27'd0, done, error, cmd_req, sw_start, low_volt_ok}, 32'd0);
    endtask

    // No UHS mode, 3.3 V field 37 (148 mA); 1.8 V field large but rail unsupported.
    task automatic test_plain_no_xpc();
        logic [31:0] seen;
        int p0;
        uhs_caps = 3'b000; volt_caps = 3'b001; max_current = {8'hFF, 8'hFF, 8'd37};
        if_cond_ok = 1'b0; spi_mode = 1'b0;
        p0 = sw_pulses;
        kick();
        answer(32'h80FF8000, 1'b0, seen);
        chk("R2 no s18 without modes", 32'(seen[24]), 32'd0);
        chk("R3 field 37 below limit", 32'(seen[28]), 32'd0);
        chk("R5 argument word", seen, 32'h00FF8000);
        wait_done();
        chk("R7 no switch", 32'(sw_pulses - p0), 32'd0);
    endtask

    // SDR104 only, 1.8 V field 38 (152 mA), card accepts, switch succeeds.
    task automatic test_switch_ok();
        logic [31:0] seen;
        int p0;
        uhs_caps = 3'b010; volt_caps = 3'b100; max_current = {8'd38, 8'h00, 8'h00};
        if_cond_ok = 1'b1;
        p0 = sw_pulses;
        kick();
        answer(32'hC1FF8000, 1'b0, seen);
        chk("R2 R3 R5 argument with s18 and xpc", seen, 32'h51FF8000);
        switch_result(1'b1);
        wait_done();
        chk("R8 error clear", 32'(error), 32'd0);
        chk("R8 low_volt_ok", 32'(low_volt_ok), 32'd1);
        chk("R8 final_arg", final_arg, 32'h51FF8000);
        chk("R7 one kick", 32'(sw_pulses - p0), 32'd1);
    endtask

    // DDR50; 3.0 V field maxed but rail unsupported; card lacks S18A.
    task automatic test_ignored_field();
        logic [31:0] seen;
        int p0;
        uhs_caps = 3'b100; volt_caps = 3'b001; max_current = {8'h00, 8'hFF, 8'h10};
        if_cond_ok = 1'b1;
        p0 = sw_pulses;
        kick();
        answer(32'hC0FF8000, 1'b0, seen);
        chk("R4 unsupported rail ignored", 32'(seen[28]), 32'd0);
        chk("R2 DDR50 sets s18", 32'(seen[24]), 32'd1);
        wait_done();
        chk("R7 no switch without S18A", 32'(sw_pulses - p0), 32'd0);
        chk("R7 low_volt_ok clear", 32'(low_volt_ok), 32'd0);
    endtask

    // SPI mode blocks the switch even when the response accepts 1.8 V.
    task automatic test_spi();
        logic [31:0] seen;
        int p0;
        uhs_caps = 3'b001; volt_caps = 3'b010; max_current = {8'h00, 8'h40, 8'h00};
        if_cond_ok = 1'b1; spi_mode = 1'b1;
        p0 = sw_pulses;
        kick();
        answer(32'hC1FF8000, 1'b0, seen);
        chk("R3 3.0 V rail sets xpc", seen, 32'h51FF8000);
        wait_done();
        chk("R7 no switch in SPI", 32'(sw_pulses - p0), 32'd0);
        chk("R7 clean finish in SPI", {30'd0, error, low_volt_ok}, 32'd0);
        spi_mode = 1'b0;
    endtask

    // First switch fails, retry drops bit 24, second response needs no switch.
    task automatic test_retry_ok();
        logic [31:0] seen;
        uhs_caps = 3'b001; volt_caps = 3'b000; max_current = '0; if_cond_ok = 1'b1;
        kick();
        answer(32'hC1FF8000, 1'b0, seen);
        chk("R9 first argument", seen, 32'h41FF8000);
        switch_result(1'b0);
        answer(32'hC0FF8000, 1'b0, seen);
        chk("R9 retry argument", seen, 32'h40FF8000);
        wait_done();
        chk("R9 clean end", {30'd0, error, low_volt_ok}, 32'd0);
        chk("R9 final_arg", final_arg, 32'h40FF8000);
    endtask

    // Both switches fail.
    task automatic test_retry_fail();
        logic [31:0] seen;
        int p0;
        p0 = sw_pulses;
        kick();
        answer(32'hC1FF8000, 1'b0, seen);
        switch_result(1'b0);
        answer(32'hC1FF8000, 1'b0, seen);
        switch_result(1'b0);
        wait_done();
        chk("R10 error after second failure", 32'(error), 32'd1);
        chk("R10 two kicks", 32'(sw_pulses - p0), 32'd2);
    endtask

    // Command error ends the run with error and no switch.
    task automatic test_cmd_err();
        logic [31:0] seen;
        int p0;
        p0 = sw_pulses;
        kick();
        answer(32'hC1FF8000, 1'b1, seen);
        wait_done();
        chk("R11 error on command failure", 32'(error), 32'd1);
        chk("R11 no kick", 32'(sw_pulses - p0), 32'd0);
    endtask

    // Late acknowledge, then done holding and clearing on restart.
    task automatic test_hold_and_restart();
        logic [31:0] seen;
        logic [31:0] first;
        uhs_caps = 3'b000; volt_caps = 3'b000; if_cond_ok = 1'b0;
        kick();
        wait_req();
        first = cmd_arg;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R6 request held", {31'd0, cmd_req}, 32'd1);
            chk("R6 argument stable", cmd_arg, first);
        end
        answer(32'h80FF8000, 1'b0, seen);
        wait_done();
        repeat (3) @(negedge clk);
        chk("R12 done held", 32'(done), 32'd1);
        kick();
        chk("R12 done cleared by start", 32'(done), 32'd0);
        answer(32'h80FF8000, 1'b0, seen);
        wait_done();
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_plain_no_xpc();
        test_switch_ok();
        test_ignored_field();
        test_spi();
        test_retry_ok();
        test_retry_fail();
        test_cmd_err();
        test_hold_and_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule